// File: doc/BRIEF.md
# Alarm/Control Code-Word Serializer

This block drives the one-bit-per-frame overhead channel that carries alarm and control code words in a DS3 C-bit parity framer. A processor writes an 8-bit code byte of the form 0mmmxxx0 and reads a status bit. The framer pulses a strobe once per M-frame, and on each strobe the block puts out one bit. A message is a flag of eight ones followed by the code byte, so it spans 16 strobes. The block keeps sending the last byte it took until a new one is written.

There are two interrupt modes. In single mode the status bit is set after every complete message. In repetitive mode the message goes out in bursts of ten, and the status bit is set at the end of each burst. A written byte is held as pending. It is taken at the next message boundary in single mode, and at the next burst boundary in repetitive mode. A byte with its top or bottom bit set is malformed. Once such a byte is taken, the line falls back to all-ones idle and no status is raised.

The channel exists only in C-bit framing. With that mode off, the line stays at ones and nothing is counted.

Top module: `feac_tx`

## Requirements
- R1: A valid message is 8 ones, then the code byte LSB first. Each bit is sent on one strobe. `tx_bit` changes on the clock edge that samples `frame_stb` high and holds between strobes.
- R2: A byte is valid only when bit 7 and bit 0 are both 0. Once a malformed byte is taken, `tx_bit` stays 1 and `stat_flag` is not set until a valid byte is taken.
- R3: In single mode (`rep_mode`=0), `stat_flag` rises on the edge that samples the strobe carrying the 16th bit of each valid message.
- R4: With no new write, the current byte is sent again message after message.
- R5: In repetitive mode (`rep_mode`=1), `stat_flag` is set only after every 10th consecutive valid message. A pending byte is taken only after such a burst completes, or at once when the line is idling.
- R6: In single mode, a byte written during a message is taken at the next message boundary, and the current message finishes unchanged.
- R7: A pulse on `stat_rd` clears `stat_flag` on the next edge. A set in the same cycle wins over the clear.
- R8: While `cbit_mode`=0, `tx_bit` is 1 from the next edge, no status is raised, and the burst count restarts. After re-enabling, the next strobe starts a new message at its first flag bit.
- R9: After reset, `tx_bit`=1, `stat_flag`=0, `irq`=0, and the line idles until a valid byte is written.
- R10: `irq` equals `stat_flag` AND `irq_en` and follows `irq_en` with no delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cbit_mode | input | 1 | 1 when the framer runs C-bit framing; 0 disables the channel |
| rep_mode | input | 1 | 0 = single mode, 1 = repetitive (ten-message) mode |
| irq_en | input | 1 | Interrupt enable |
| frame_stb | input | 1 | One-cycle request for the next channel bit |
| wr_en | input | 1 | Write strobe for the code byte |
| wr_data | input | BYTE_W | Code byte to send |
| stat_rd | input | 1 | Status read strobe; clears the status bit |
| tx_bit | output | 1 | Channel bit, held between strobes |
| stat_flag | output | 1 | Message/burst-sent status bit |
| irq | output | 1 | Interrupt request |

## Verification
`tx_bit` and `stat_flag` are due one clock after the edge that samples a strobe, write or read. `irq` follows `irq_en` in the same cycle. The bench drives every input just after a falling edge. A behavioural model, built from a bit queue and integer counters, advances on the rising edge. Each falling edge compares the outputs against the model, before any new input is applied. Strobes arrive every fourth cycle. Writes land mid-message and status reads at several periods, including a read on every cycle, so that a read meets a set in the same cycle.

// File: rtl/feac_tx_pkg.sv
package feac_tx_pkg;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_REPEAT = 1'b1
  } feac_mode_e;

  localparam int DEF_BYTE_W    = 8;
  localparam int DEF_FLAG_LEN  = 8;
  localparam int DEF_REP_COUNT = 10;

endpackage

// File: rtl/feac_rst_sync.sv
module feac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/feac_serializer.sv
module feac_serializer #(
  parameter int MSG_LEN = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               stb,
  input  logic [MSG_LEN-1:0] frame_word,
  output logic               tx_bit,
  output logic               boundary,
  output logic               msg_end
);

  localparam int PW = $clog2(MSG_LEN);
  localparam logic [PW-1:0] LAST_POS = PW'(MSG_LEN - 1);

  logic [PW-1:0]      pos_q, pos_d;
  logic [MSG_LEN-1:0] sh_q, sh_d;
  logic               tx_q, tx_d;

  assign boundary = en && stb && (pos_q == '0);
  assign msg_end  = en && stb && (pos_q == LAST_POS);

  always_comb begin
    pos_d = pos_q;
    sh_d  = sh_q;
    tx_d  = tx_q;
    if (!en) begin
      pos_d = '0;
      tx_d  = 1'b1;
    end else if (stb) begin
      if (pos_q == '0) begin
        tx_d = frame_word[0];
        sh_d = {1'b1, frame_word[MSG_LEN-1:1]};
      end else begin
        tx_d = sh_q[0];
        sh_d = {1'b1, sh_q[MSG_LEN-1:1]};
      end
      pos_d = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      sh_q  <= '1;
      tx_q  <= 1'b1;
    end else begin
      pos_q <= pos_d;
      sh_q  <= sh_d;
      tx_q  <= tx_d;
    end
  end

  assign tx_bit = tx_q;

  // R1
  hold_between_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !stb) |=> $stable(tx_q));

  // R8
  disabled_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> tx_q);

endmodule

// File: rtl/feac_msg_sel.sv
module feac_msg_sel
  import feac_tx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int FLAG_LEN  = 8,
  parameter int REP_COUNT = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       rep_mode,
  input  logic                       boundary,
  input  logic                       msg_end,
  input  logic                       wr_en,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [BYTE_W+FLAG_LEN-1:0] frame_word,
  output logic                       burst_done
);

  localparam int RW = (REP_COUNT > 1) ? $clog2(REP_COUNT) : 1;
  localparam logic [RW-1:0] REP_LAST = RW'(REP_COUNT - 1);

  feac_mode_e mode;
  logic [BYTE_W-1:0] cur_q, cur_d, wbuf_q, wbuf_d, sel;
  logic              pend_q, pend_d;
  logic [RW-1:0]     rep_q, rep_d;
  logic              cur_ok, sel_ok, adopt, rep_last;

  assign mode     = feac_mode_e'(rep_mode);
  assign cur_ok   = !cur_q[BYTE_W-1] && !cur_q[0];
  assign rep_last = (rep_q == REP_LAST);
  assign adopt    = pend_q && ((mode == MODE_SINGLE) || (rep_q == '0) || !cur_ok);
  assign sel      = adopt ? wbuf_q : cur_q;
  assign sel_ok   = !sel[BYTE_W-1] && !sel[0];

  always_comb begin
    if (sel_ok) frame_word = {sel, {FLAG_LEN{1'b1}}};
    else        frame_word = '1;
  end

  assign burst_done = msg_end && cur_ok && ((mode == MODE_SINGLE) || rep_last);

  always_comb begin
    cur_d  = cur_q;
    wbuf_d = wbuf_q;
    pend_d = pend_q;
    rep_d  = rep_q;
    if (boundary && adopt) begin
      cur_d  = wbuf_q;
      pend_d = 1'b0;
      rep_d  = '0;
    end
    if (msg_end && cur_ok && (mode == MODE_REPEAT))
      rep_d = rep_last ? '0 : rep_q + 1'b1;
    if (!en)
      rep_d = '0;
    if (wr_en) begin
      wbuf_d = wr_data;
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '1;
      wbuf_q <= '1;
      pend_q <= 1'b0;
      rep_q  <= '0;
    end else begin
      cur_q  <= cur_d;
      wbuf_q <= wbuf_d;
      pend_q <= pend_d;
      rep_q  <= rep_d;
    end
  end

  // R5
  rep_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rep_q) < REP_COUNT);

endmodule

// File: rtl/feac_status.sv
module feac_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic stat_flag,
  output logic irq
);

  logic stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (set)      stat_d = 1'b1;
    else if (clr) stat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= stat_d;
  end

  assign stat_flag = stat_q;
  assign irq       = stat_q && irq_en;

endmodule

// File: rtl/feac_tx.sv
module feac_tx
  import feac_tx_pkg::*;
#(
  parameter int BYTE_W    = DEF_BYTE_W,
  parameter int FLAG_LEN  = DEF_FLAG_LEN,
  parameter int REP_COUNT = DEF_REP_COUNT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cbit_mode,
  input  logic              rep_mode,
  input  logic              irq_en,
  input  logic              frame_stb,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              stat_rd,
  output logic              tx_bit,
  output logic              stat_flag,
  output logic              irq
);

  localparam int MSG_LEN = BYTE_W + FLAG_LEN;

  logic               rst_i;
  logic [MSG_LEN-1:0] frame_word;
  logic               boundary, msg_end, burst_done;

  feac_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i)
  );

  feac_serializer #(.MSG_LEN(MSG_LEN)) u_ser (
    .clk        (clk),
    .rst_n      (rst_i),
    .en         (cbit_mode),
    .stb        (frame_stb),
    .frame_word (frame_word),
    .tx_bit     (tx_bit),
    .boundary   (boundary),
    .msg_end    (msg_end)
  );

  feac_msg_sel #(
    .BYTE_W    (BYTE_W),
    .FLAG_LEN  (FLAG_LEN),
    .REP_COUNT (REP_COUNT)
  ) u_sel (
    .clk        (clk),
    .rst_n      (rst_i),
    .en         (cbit_mode),
    .rep_mode   (rep_mode),
    .boundary   (boundary),
    .msg_end    (msg_end),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .frame_word (frame_word),
    .burst_done (burst_done)
  );

  feac_status u_stat (
    .clk       (clk),
    .rst_n     (rst_i),
    .set       (burst_done),
    .clr       (stat_rd),
    .irq_en    (irq_en),
    .stat_flag (stat_flag),
    .irq       (irq)
  );

  // R3
  stat_rise_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(stat_flag) |-> $past(msg_end));

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (stat_rd && !burst_done) |=> !stat_flag);

endmodule

// File: tb/feac_tx_tb_top.sv
module feac_tx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int STB_GAP    = 4;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cbit_mode = 1'b1;
  logic       rep_mode = 1'b0;
  logic       irq_en = 1'b1;
  logic       frame_stb = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       stat_rd = 1'b0;
  logic       tx_bit, stat_flag, irq;

  int    vectors = 0;
  int    miscompares = 0;
  int    cycles = 0;
  string phase = "R9 reset";

  // reference model state
  bit       m_tx, m_stat, m_pend;
  bit [7:0] m_cur, m_wbuf;
  int       m_rep;
  bit       q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  feac_tx dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cbit_mode (cbit_mode),
    .rep_mode  (rep_mode),
    .irq_en    (irq_en),
    .frame_stb (frame_stb),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .stat_rd   (stat_rd),
    .tx_bit    (tx_bit),
    .stat_flag (stat_flag),
    .irq       (irq)
  );

  function automatic bit code_ok(bit [7:0] b);
    return !b[7] && !b[0];
  endfunction

  always @(posedge clk) begin
    bit set_now;
    bit adopt;
    set_now = 1'b0;
    if (!rst_n) begin
      m_tx = 1'b1; m_stat = 1'b0; m_pend = 1'b0;
      m_cur = 8'hFF; m_wbuf = 8'hFF; m_rep = 0;
      q.delete();
    end else begin
      if (!cbit_mode) begin
        m_tx = 1'b1;
        q.delete();
        m_rep = 0;
      end else if (frame_stb) begin
        if (q.size() == 0) begin
          adopt = m_pend && (!rep_mode || m_rep == 0 || !code_ok(m_cur));
          if (adopt) begin
            m_cur = m_wbuf; m_pend = 1'b0; m_rep = 0;
          end
          if (code_ok(m_cur)) begin
            for (int i = 0; i < 8; i++) q.push_back(1'b1);
            for (int i = 0; i < 8; i++) q.push_back(m_cur[i]);
          end else begin
            for (int i = 0; i < 16; i++) q.push_back(1'b1);
          end
        end
        m_tx = q.pop_front();
        if (q.size() == 0 && code_ok(m_cur)) begin
          if (!rep_mode) set_now = 1'b1;
          else if (m_rep == 9) begin
            set_now = 1'b1; m_rep = 0;
          end else m_rep++;
        end
      end
      if (set_now) m_stat = 1'b1;
      else if (stat_rd) m_stat = 1'b0;
      if (wr_en) begin
        m_wbuf = wr_data; m_pend = 1'b1;
      end
    end
  end

  task automatic report(string what, bit act, bit exp);
    miscompares++;
    $display("FAIL %s [%s] actual=%0b expected=%0b at cycle %0d", what, phase, act, exp, cycles);
  endtask

  task automatic compare();
    vectors++;
    if (tx_bit !== m_tx) report("R1 tx_bit", tx_bit, m_tx);
    if (stat_flag !== m_stat) report("R3 stat_flag", stat_flag, m_stat);
    if (irq !== (m_stat && irq_en)) report("R10 irq", irq, m_stat && irq_en);
  endtask

  task automatic tick(bit stb, bit rd);
    @(negedge clk);
    compare();
    frame_stb = stb; stat_rd = rd; wr_en = 1'b0;
  endtask

  task automatic run(int n_stb, int rd_per);
    for (int c = 0; c < n_stb * STB_GAP; c++)
      tick((c % STB_GAP) == 0, rd_per != 0 && (c % rd_per) == rd_per - 1);
  endtask

  task automatic write(bit [7:0] b);
    @(negedge clk);
    compare();
    frame_stb = 1'b0; stat_rd = 1'b0; wr_en = 1'b1; wr_data = b;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      miscompares++;
      $display("FAIL watchdog [%s] actual=running expected=finished", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset state seen at the ports
    vectors++;
    if (tx_bit !== 1'b1) report("R9 tx_bit after reset", tx_bit, 1'b1);
    vectors++;
    if (stat_flag !== 1'b0) report("R9 stat_flag after reset", stat_flag, 1'b0);
    vectors++;
    if (irq !== 1'b0) report("R9 irq after reset", irq, 1'b0);

    phase = "R9 idle before first write";
    run(20, 0);

    phase = "R1 R3 R4 single mode repeats";
    write(8'h1A);
    run(50, 29);

    phase = "R6 mid-message write";
    run(5, 0);
    write(8'h3C);
    run(40, 13);

    phase = "R10 irq masked";
    irq_en = 1'b0;
    run(20, 0);
    irq_en = 1'b1;
    run(8, 3);

    phase = "R2 malformed byte idles";
    write(8'h81);
    run(60, 11);

    phase = "R2 valid byte resumes";
    write(8'h5A);
    run(40, 17);

    phase = "R8 channel disabled";
    run(7, 0);
    cbit_mode = 1'b0;
    run(10, 5);
    cbit_mode = 1'b1;
    run(40, 9);

    phase = "R5 repetitive bursts";
    rep_mode = 1'b1;
    write(8'h24);
    run(16 * 25, 23);
    write(8'h42);
    run(16 * 22, 0);
    run(16 * 12, 7);

    phase = "R5 malformed after burst";
    write(8'h01);
    run(16 * 14, 19);

    phase = "R7 read meets set";
    rep_mode = 1'b0;
    write(8'h66);
    run(40, 1);
    run(20, 0);

    tick(1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule